// File: doc/BRIEF.md
# SMBus Target with Alert Response

This block is the serial-bus target of a monitoring device. It watches the SCL and SDA lines and answers transfers sent to its own 7-bit address. A write carries a register pointer byte and then data bytes. A read returns the byte at the current pointer, and a repeated START may sit between the pointer write and the read. Behind the bus sits a small register file with scratch registers, a control register and a status register that latches event inputs from the monitoring logic.

When an enabled status event is pending, the block pulls an active-low, open-drain alert line low on the next monitoring-cycle strobe. The host then issues a one-byte read to the Alert Response Address. The block acknowledges that read only if the interrupt enable is set and a status bit is pending. It replies with its own address, and this reply clears the interrupt enable, which releases the alert line. A START followed at once by a STOP returns the interface to idle. SCL held low for about 30 ms also returns it to idle and releases SDA. The block never drives SCL, so other devices may stretch the clock.

Top module: `smbus_alert_target`

## Requirements
- R1: After reset `sda_pd_o` and `alert_pd_o` are 0, and the control register at pointer 0x7C reads 0x00.
- R2: A write (START, {OWN_ADDR,0}, pointer, data, STOP) is acknowledged on every byte and stores the data. Scratch registers sit at pointers 0..NUM_SCRATCH-1. A read (START, {OWN_ADDR,0}, pointer, repeated START, {OWN_ADDR,1}, byte, NACK, STOP) returns the stored byte. Unmapped pointers read 0x00.
- R3: An address byte that matches neither the own address nor a read to 7'b0001100 is not acknowledged. A write to 7'b0001100 is also not acknowledged. In both cases `sda_pd_o` stays 0 until the next START or STOP.
- R4: The status register at pointer 0x41 sets bit n whenever `evt_i[n]` is high. Reading it returns the latched bits and clears every bit whose input is not high at that moment.
- R5: `alert_pd_o` rises only in the cycle after a `mon_strobe_i` pulse, and only while bit 2 of 0x7C is 1 and the status register is nonzero. It falls when either condition goes away.
- R6: A read to the Alert Response Address 7'b0001100 is acknowledged only while bit 2 of 0x7C is 1 and the status register is nonzero. Otherwise it is not acknowledged.
- R7: The byte returned to an acknowledged alert-response read is {OWN_ADDR, 1'b0}.
- R8: Acknowledging an alert-response read clears bit 2 of 0x7C, and `alert_pd_o` is 0 by the end of that transfer.
- R9: If software sets bit 2 of 0x7C again while status is still pending, `alert_pd_o` stays 0 until the next `mon_strobe_i` pulse and is 1 after it.
- R10: A START followed by a STOP, including one that breaks into a partly sent byte, leaves `sda_pd_o` at 0 and the next transfer works normally.
- R11: If SCL stays low for TIMEOUT_CYCLES = CLK_FREQ_HZ/1e6 * TIMEOUT_US cycles, the block releases SDA and returns to idle. It releases no earlier than that count and no later than 16 cycles after it.
- R12: The block has no SCL output. A low stretch of SCL between bits that is shorter than the timeout does not disturb a transfer, and `sda_pd_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pd_o | output | 1 | Pull-down enable for SDA |
| alert_pd_o | output | 1 | Pull-down enable for the alert line |
| evt_i | input | 8 | Status event inputs from monitoring logic |
| mon_strobe_i | input | 1 | One-cycle pulse at each monitoring cycle |

## Verification
The assertions assume that SCL stays low for longer than the input filter delay after each falling edge. The SDA pull-down moves a few cycles after the filtered edge, so it must land inside that low phase. They also assume that SDA is never moved by the host while SCL is high, except to form START or STOP. The host model in the bench changes SDA only a quarter bit after SCL falls, holds every SCL phase at least 25 cycles, and leaves SDA released whenever the target may drive it. Stretches longer than the timeout are used only in the test of the timeout itself.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  localparam int unsigned EVT_W = 8;
  localparam logic [6:0] ARA_ADDR    = 7'b0001100;
  localparam logic [7:0] CTRL_PTR    = 8'h7C;
  localparam int unsigned INT_EN_BIT = 2;
  localparam logic [7:0] STATUS_PTR  = 8'h41;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_ADDR, RX_PTR, RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/smbus_line_filter.sv
module smbus_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/smbus_scl_timeout.sv
module smbus_scl_timeout #(
  parameter int unsigned LIMIT = 3000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (scl_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  // single pulse once per low stretch
  assign expire_o = !scl_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/smbus_tgt_bus.sv
module smbus_tgt_bus
  import smbus_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       timeout_i,
  input  logic       ara_ok_i,
  input  logic [7:0] reg_rdata_i,
  output logic       sda_pd_o,
  output logic       ara_ack_o,
  output logic       reg_wr_o,
  output logic       reg_rd_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o
);
  bus_state_e state_q, state_n;
  rx_kind_e   kind_q, kind_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] shift_q, shift_n;
  logic [7:0] ptr_q, ptr_n;
  logic       rnw_q, rnw_n;
  logic       ara_q, ara_n;
  logic       mack_q, mack_n;
  logic       pd_q, pd_n;
  logic       scl_q, sda_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] tx_byte;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign tx_byte  = ara_q ? {OWN_ADDR, 1'b0} : reg_rdata_i;

  always_comb begin
    state_n   = state_q;
    kind_n    = kind_q;
    cnt_n     = cnt_q;
    shift_n   = shift_q;
    ptr_n     = ptr_q;
    rnw_n     = rnw_q;
    ara_n     = ara_q;
    mack_n    = mack_q;
    pd_n      = pd_q;
    ara_ack_o = 1'b0;
    reg_wr_o  = 1'b0;
    reg_rd_o  = 1'b0;

    if (timeout_i || stop_c) begin
      state_n = ST_IDLE;
      pd_n    = 1'b0;
    end else if (start_c) begin
      state_n = ST_RX;
      kind_n  = RX_ADDR;
      cnt_n   = '0;
      pd_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q < 4'd8) begin
            shift_n = {shift_q[6:0], sda_i};
            cnt_n   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            state_n = ST_ACK;
            pd_n    = 1'b1;
            unique case (kind_q)
              RX_ADDR: begin
                if (shift_q[7:1] == OWN_ADDR) begin
                  rnw_n  = shift_q[0];
                  ara_n  = 1'b0;
                  kind_n = RX_PTR;
                end else if (shift_q[7:1] == ARA_ADDR && shift_q[0] && ara_ok_i) begin
                  rnw_n     = 1'b1;
                  ara_n     = 1'b1;
                  ara_ack_o = 1'b1;
                end else begin
                  state_n = ST_IGNORE;
                  pd_n    = 1'b0;
                end
              end
              RX_PTR: begin
                ptr_n  = shift_q;
                kind_n = RX_DATA;
              end
              default: reg_wr_o = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rnw_q) begin
              shift_n  = tx_byte;
              reg_rd_o = !ara_q;
              pd_n     = ~tx_byte[7];
              state_n  = ST_TX;
            end else begin
              pd_n    = 1'b0;
              state_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              pd_n    = 1'b0;
              state_n = ST_TX_ACK;
            end else begin
              shift_n = {shift_q[6:0], 1'b0};
              pd_n    = ~shift_q[6];
              cnt_n   = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              shift_n  = tx_byte;
              reg_rd_o = !ara_q;
              pd_n     = ~tx_byte[7];
              cnt_n    = '0;
              state_n  = ST_TX;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_ADDR;
      cnt_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      rnw_q   <= 1'b0;
      ara_q   <= 1'b0;
      mack_q  <= 1'b0;
      pd_q    <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      shift_q <= shift_n;
      ptr_q   <= ptr_n;
      rnw_q   <= rnw_n;
      ara_q   <= ara_n;
      mack_q  <= mack_n;
      pd_q    <= pd_n;
      scl_q   <= scl_i;
      sda_q   <= sda_i;
    end
  end

  assign sda_pd_o    = pd_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = shift_q;
endmodule

// File: rtl/smbus_tgt_regs.sv
module smbus_tgt_regs
  import smbus_tgt_pkg::*;
#(
  parameter int unsigned NUM_SCRATCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             ara_ack_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             mon_strobe_i,
  output logic [7:0]       rdata_o,
  output logic             ara_ok_o,
  output logic             int_en_o,
  output logic             alert_pd_o
);
  localparam int unsigned IW = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

  logic [7:0]       scratch_q [NUM_SCRATCH];
  logic [7:0]       ctrl_q;
  logic [EVT_W-1:0] status_q;
  logic             alert_q;
  logic             status_rd;

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scratch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           scratch_q[i] <= '0;
      else if (wr_i && addr_i == 8'(i))      scratch_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ara_ack_i) begin
      ctrl_q[INT_EN_BIT] <= 1'b0;
    end else if (wr_i && addr_i == CTRL_PTR) begin
      ctrl_q <= wdata_i;
    end
  end

  assign status_rd = rd_i && addr_i == STATUS_PTR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_rd ? '0 : status_q) | evt_i;
  end

  assign int_en_o = ctrl_q[INT_EN_BIT];
  assign ara_ok_o = int_en_o && (|status_q);

  // assert only on a monitoring strobe, hold while still qualified
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= ara_ok_o && (alert_q || mon_strobe_i);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < 8'(NUM_SCRATCH))  rdata_o = scratch_q[addr_i[IW-1:0]];
    else if (addr_i == CTRL_PTR)   rdata_o = ctrl_q;
    else if (addr_i == STATUS_PTR) rdata_o = 8'(status_q);
  end

  assign alert_pd_o = alert_q;
endmodule

// File: rtl/smbus_alert_target.sv
module smbus_alert_target
  import smbus_tgt_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR    = 7'h2E,
  parameter int unsigned NUM_SCRATCH = 4,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned CLK_FREQ_HZ = 100000000,
  parameter int unsigned TIMEOUT_US  = 30000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pd_o,
  output logic             alert_pd_o,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             mon_strobe_i
);
  localparam int unsigned TIMEOUT_CYCLES = (CLK_FREQ_HZ / 1000000) * TIMEOUT_US;
  localparam int unsigned NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f, expire;
  logic       ara_ok, ara_ack, int_en;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_filt
    smbus_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[i]),
      .line_o(filt_lines[i])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  smbus_scl_timeout #(.LIMIT(TIMEOUT_CYCLES)) i_timeout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_f),
    .expire_o(expire)
  );

  smbus_tgt_bus #(.OWN_ADDR(OWN_ADDR)) i_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .timeout_i  (expire),
    .ara_ok_i   (ara_ok),
    .reg_rdata_i(reg_rdata),
    .sda_pd_o   (sda_pd_o),
    .ara_ack_o  (ara_ack),
    .reg_wr_o   (reg_wr),
    .reg_rd_o   (reg_rd),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata)
  );

  smbus_tgt_regs #(.NUM_SCRATCH(NUM_SCRATCH)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .addr_i      (reg_addr),
    .wdata_i     (reg_wdata),
    .ara_ack_i   (ara_ack),
    .evt_i       (evt_i),
    .mon_strobe_i(mon_strobe_i),
    .rdata_o     (reg_rdata),
    .ara_ok_o    (ara_ok),
    .int_en_o    (int_en),
    .alert_pd_o  (alert_pd_o)
  );
endmodule

// File: rtl/smbus_alert_target_chk.sv
module smbus_alert_target_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 3000000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pd_o,
  input logic alert_pd_o,
  input logic mon_strobe_i,
  input logic int_en_i,
  input logic ara_ack_i
);
  logic [31:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    low_cnt_q <= '0;
    else if (scl_i)                 low_cnt_q <= '0;
    else if (low_cnt_q != '1)       low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R5
  alert_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_pd_o) |-> $past(mon_strobe_i));

  // R5
  alert_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_en_i) |=> !alert_pd_o);

  // R8
  ara_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_ack_i |=> !int_en_i);

  // R11
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt_q > 32'(TIMEOUT_CYCLES) + 32'd16) |-> !sda_pd_o);

  // R12
  sda_moves_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_i);
endmodule

bind smbus_alert_target smbus_alert_target_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_smbus_alert_target_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_pd_o    (sda_pd_o),
  .alert_pd_o  (alert_pd_o),
  .mon_strobe_i(mon_strobe_i),
  .int_en_i    (int_en),
  .ara_ack_i   (ara_ack)
);

// File: tb/test_smbus_alert_target.sv
`timescale 1ns/1ps
module test_smbus_alert_target;
  localparam logic [6:0] OWN = 7'h2E;
  localparam logic [6:0] ARA = 7'b0001100;
  localparam int Q  = 25;
  localparam int HP = 50;
  localparam int TO = 3000; // 200 cycles/us * 15 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic [7:0] evt = '0;
  logic strobe = 1'b0;
  logic sda_pd, alert_pd;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_host & ~sda_pd;

  smbus_alert_target #(
    .OWN_ADDR(OWN), .NUM_SCRATCH(4), .FILT_LEN(3),
    .CLK_FREQ_HZ(200000000), .TIMEOUT_US(15)
  ) i_smbus_alert_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pd_o(sda_pd), .alert_pd_o(alert_pd),
    .evt_i(evt), .mon_strobe_i(strobe)
  );

  // R12 / R3 monitors
  logic pd_prev = 1'b0;
  int   pd_move_bad = 0;
  logic watch_pd = 1'b0;
  int   pd_seen = 0;
  always @(negedge clk) begin
    if (rst_n && sda_pd != pd_prev && scl) pd_move_bad++;
    if (watch_pd && sda_pd) pd_seen++;
    pd_prev = sda_pd;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_host = 1'b0; wclk(HP); scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wclk(Q); sda_host = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); sda_host = 1'b0; wclk(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(Q); sda_host = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_host = 1'b1; wclk(HP);
  endtask

  task automatic bit_wr(input logic b);
    wclk(Q); sda_host = b; wclk(Q); scl = 1'b1; wclk(HP); scl = 1'b0;
  endtask

  task automatic byte_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_wr(b[i]);
    wclk(Q); sda_host = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); ack = ~sda_line; wclk(Q); scl = 1'b0;
  endtask

  task automatic byte_rd(input logic mack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(Q); sda_host = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); v = {v[6:0], sda_line}; wclk(Q); scl = 1'b0;
    end
    bit_wr(~mack);
  endtask

  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    byte_wr({OWN, 1'b0}, acks[2]);
    byte_wr(ptr, acks[1]);
    byte_wr(d, acks[0]);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] ptr, output logic [7:0] v);
    logic a;
    bus_start();
    byte_wr({OWN, 1'b0}, a);
    byte_wr(ptr, a);
    bus_rstart();
    byte_wr({OWN, 1'b1}, a);
    byte_rd(1'b0, v);
    bus_stop();
  endtask

  task automatic ara_read(output logic ack, output logic [7:0] v);
    v = '0;
    bus_start();
    byte_wr({ARA, 1'b1}, ack);
    if (ack) byte_rd(1'b0, v);
    bus_stop();
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    evt = e; wclk(1); evt = '0; wclk(2);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; wclk(1); strobe = 1'b0; wclk(3);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 sda_pd after reset", sda_pd, 1'b0);
    chk("R1 alert after reset", alert_pd, 1'b0);
    reg_read(8'h7C, v);
    chk("R1 ctrl reset value", v, 8'h00);
  endtask

  task automatic t_rw();
    logic [2:0] a;
    logic [7:0] v;
    reg_write(8'h00, 8'hA5, a);
    chk("R2 write acks", a, 3'b111);
    reg_write(8'h03, 8'h3C, a);
    chk("R2 write acks last reg", a, 3'b111);
    reg_read(8'h00, v);
    chk("R2 readback 0x00", v, 8'hA5);
    reg_read(8'h03, v);
    chk("R2 readback 0x03", v, 8'h3C);
    reg_read(8'h20, v);
    chk("R2 unmapped reads zero", v, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic a;
    logic [7:0] v;
    pd_seen = 0;
    bus_start();
    watch_pd = 1'b1;
    byte_wr({7'h2F, 1'b0}, a);
    byte_wr(8'h00, a);
    watch_pd = 1'b0;
    bus_stop();
    chk("R3 foreign address no pull-down", pd_seen, 0);
    bus_start();
    byte_wr({ARA, 1'b0}, a);
    bus_stop();
    chk("R3 alert address write nack", a, 1'b0);
    ara_read(a, v);
    chk("R6 alert read nack while disabled", a, 1'b0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    pulse_evt(8'h05);
    pulse_strobe();
    chk("R5 no alert while enable clear", alert_pd, 1'b0);
    reg_read(8'h41, v);
    chk("R4 status latched", v, 8'h05);
    reg_read(8'h41, v);
    chk("R4 status cleared by read", v, 8'h00);
  endtask

  task automatic t_alert();
    logic [2:0] a3;
    logic a;
    logic [7:0] v;
    reg_write(8'h7C, 8'h04, a3);
    reg_read(8'h7C, v);
    chk("R8 ctrl set", v, 8'h04);
    pulse_evt(8'h10);
    wclk(20);
    chk("R5 no alert before strobe", alert_pd, 1'b0);
    pulse_strobe();
    chk("R5 alert after strobe", alert_pd, 1'b1);
    ara_read(a, v);
    chk("R6 alert read acked", a, 1'b1);
    chk("R7 alert reply byte", v, {OWN, 1'b0});
    chk("R8 alert released", alert_pd, 1'b0);
    reg_read(8'h7C, v);
    chk("R8 enable cleared", v, 8'h00);
  endtask

  task automatic t_rearm();
    logic [2:0] a3;
    logic a;
    logic [7:0] v;
    reg_write(8'h7C, 8'h04, a3);
    wclk(20);
    chk("R9 no reassert before strobe", alert_pd, 1'b0);
    pulse_strobe();
    chk("R9 reassert on strobe", alert_pd, 1'b1);
    reg_read(8'h41, v);
    chk("R4 status still pending", v, 8'h10);
    chk("R5 alert drops with empty status", alert_pd, 1'b0);
    ara_read(a, v);
    chk("R6 alert read nack with empty status", a, 1'b0);
    reg_write(8'h7C, 8'h00, a3);
  endtask

  task automatic t_bus_reset();
    logic a;
    logic [7:0] v;
    bus_start();
    bus_stop();
    chk("R10 start-stop idle", sda_pd, 1'b0);
    bus_start();
    byte_wr({OWN, 1'b0}, a);
    bit_wr(1'b0); bit_wr(1'b1); bit_wr(1'b0);
    bus_rstart();
    bus_stop();
    chk("R10 abort mid byte", sda_pd, 1'b0);
    reg_read(8'h00, v);
    chk("R10 transfer after reset", v, 8'hA5);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    logic [7:0] b;
    b = {OWN, 1'b0};
    bus_start();
    for (int i = 7; i >= 0; i--) bit_wr(b[i]);
    wclk(TO - 100);
    chk("R11 still driving before limit", sda_pd, 1'b1);
    wclk(200);
    chk("R11 released after limit", sda_pd, 1'b0);
    sda_host = 1'b1; wclk(Q); scl = 1'b1; wclk(HP);
    reg_read(8'h03, v);
    chk("R11 recovery read", v, 8'h3C);
  endtask

  task automatic t_stretch();
    logic a0, a1, a2;
    logic [7:0] v;
    logic [7:0] p;
    p = 8'h01;
    bus_start();
    byte_wr({OWN, 1'b0}, a0);
    for (int i = 7; i >= 0; i--) begin
      bit_wr(p[i]);
      if (i == 4) wclk(1000);
    end
    wclk(Q); sda_host = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); a1 = ~sda_line; wclk(Q); scl = 1'b0;
    wclk(1500);
    byte_wr(8'h77, a2);
    bus_stop();
    chk("R12 acks with stretch", {a0, a1, a2}, 3'b111);
    reg_read(8'h01, v);
    chk("R12 data after stretch", v, 8'h77);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(10);
    t_reset();
    t_rw();
    t_bad_addr();
    t_status();
    t_alert();
    t_rearm();
    t_bus_reset();
    t_timeout();
    t_stretch();
    chk("R12 sda_pd moved only with scl low", pd_move_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule